// File: doc/BRIEF.md
# Job Ring Occupancy and Interrupt Controller

This block keeps the bookkeeping for a pair of circular rings that software shares with an accelerator. One ring carries submitted jobs and the other carries completed results. Software never moves ring pointers itself. It writes how many jobs it has added to the input ring and how many results it has taken off the output ring. The block holds the input ring's pending count and read index, the output ring's filled count and write index, and the number of jobs the engine has fetched but not yet finished. The engine pulses `eng_fetch` when it takes a job, and it may do so only while `eng_can_fetch` is high. It pulses `eng_done` when it writes a result.

Completions raise an interrupt flag. With coalescing enabled, the flag is raised once a count threshold of completions is reached, or when a timer expires while at least one completion is pending. Counts that would overflow a ring are refused and reported with an error type. A ring reset command drives a three-state halt machine. In HS_RUN the block works normally. A reset command moves it to HS_DRAIN, where fetching stops and the block waits for outstanding jobs to finish. Once none are outstanding it moves to HS_DONE, clearing every counter and index on that transition. Writing one to the acknowledge bit returns it from HS_DONE to HS_RUN.

Register word addresses: 0 input size, 1 input free slots (read), 2 jobs added (write), 3 output size, 4 results removed (write), 5 output slots full (read), 6 status, 7 configuration, 8 input read index (read), 9 output write index (read), 10 command (write). Write-only and unused addresses read as zero.

Top module: `jring_ctl`

## Requirements
- R1: After reset every counter, index, ring size, status bit and configuration bit is zero, and `irq` and `eng_can_fetch` are low.
- R2: A ring size takes bits 9:0 of the write data (the value is masked with 0x3FF). The input size is written only while the input ring holds no pending job. The output size is written only while the output ring holds no result and no job is outstanding. In all other cases the write is ignored. Input free slots read as size minus pending.
- R3: Writing N to jobs-added, with N no more than the free slots, adds N pending jobs. `eng_can_fetch` is high in HS_RUN when a job is pending, the output ring's filled slots plus outstanding jobs are fewer than its size, and no stop-on-error block applies. Each accepted fetch removes one pending job and advances the read index, which wraps to 0 at the size.
- R4: Each `eng_done` with a job outstanding fills one output slot and advances the write index, which wraps at the output size. Writing N to results-removed, with N no more than the filled slots, frees N slots.
- R5: A jobs-added value larger than the free slots leaves the counters unchanged. It sets status bit 1 and sets the error type in status bits 11:8 to 9.
- R6: A results-removed value larger than the filled slots leaves the counters unchanged. It sets status bit 1 and sets the error type to 8.
- R7: Status bits 0 and 1 are write-one-to-clear. Clearing bit 1 also clears the error type to 0.
- R8: With coalescing disabled (configuration bit 1 = 0), each completion sets status bit 0.
- R9: With coalescing enabled, status bit 0 is set when the completions since the last interrupt reach the count threshold in configuration bits 15:8. A threshold of 0 acts as 1.
- R10: With coalescing enabled and a nonzero timer threshold T in configuration bits 31:16, status bit 0 is set T+1 cycles after the first pending completion if the count threshold has not been reached.
- R11: `irq` is high when status bit 0 or bit 1 is set and the mask in configuration bit 0 is 0.
- R12: With stop-on-error (configuration bit 2) set, `eng_can_fetch` stays low while status bit 1 is set.
- R13: Writing 1 to command bit 0 in HS_RUN enters HS_DRAIN, shown as status bits 3:2 = 01 (0x4), and blocks fetching. When no job is outstanding the block enters HS_DONE (status bits 3:2 = 10, 0x8) and clears all counters and indices. Add or remove writes made outside HS_RUN are refused with error type 7. Writing 1 to status bit 3 in HS_DONE returns to HS_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| eng_fetch | input | 1 | Engine takes one job from the input ring |
| eng_done | input | 1 | Engine writes one result to the output ring |
| eng_can_fetch | output | 1 | A job may be fetched this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The in-line assertions check several properties on every cycle. Each ring's occupancy stays within its size. The output ring's filled plus outstanding count never exceeds its size. A refused add or remove leaves the counters exactly where the engine alone would have moved them. The error flag and error type always agree. HS_DONE is entered only from HS_DRAIN and only with all counts empty. The coalescing counter restarts after every interrupt. Other behaviours can only be shown by the bench's scenarios, because they depend on what software and the engine do over many cycles. These are the exact index wrap points, the coalescing count and timer latencies, the mask and stop-on-error effects, and the full reset handshake.

// File: rtl/jring_pkg.sv
package jring_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_IN_SIZE    = 4'd0;
    localparam logic [REG_AW-1:0] A_IN_AVAIL   = 4'd1;
    localparam logic [REG_AW-1:0] A_IN_ADD     = 4'd2;
    localparam logic [REG_AW-1:0] A_OUT_SIZE   = 4'd3;
    localparam logic [REG_AW-1:0] A_OUT_REMOVE = 4'd4;
    localparam logic [REG_AW-1:0] A_OUT_FULL   = 4'd5;
    localparam logic [REG_AW-1:0] A_STATUS     = 4'd6;
    localparam logic [REG_AW-1:0] A_CONFIG     = 4'd7;
    localparam logic [REG_AW-1:0] A_RD_IDX     = 4'd8;
    localparam logic [REG_AW-1:0] A_WR_IDX     = 4'd9;
    localparam logic [REG_AW-1:0] A_CMD        = 4'd10;

    localparam logic [3:0] ERR_NONE    = 4'd0;
    localparam logic [3:0] ERR_RESET   = 4'd7;
    localparam logic [3:0] ERR_REM_OVF = 4'd8;
    localparam logic [3:0] ERR_ADD_OVF = 4'd9;

    // encoding equals status bits 3:2
    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_DRAIN = 2'd1,
        HS_DONE  = 2'd2
    } halt_st_e;
endpackage

// File: rtl/jring_ring.sv
module jring_ring #(
    parameter int SZ_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [SZ_W-1:0] size,
    input  logic            inc_en,
    input  logic [SZ_W-1:0] inc_amt,
    input  logic            dec_en,
    input  logic [SZ_W-1:0] dec_amt,
    input  logic            step,
    output logic [SZ_W-1:0] count,
    output logic [SZ_W-1:0] idx
);
    logic [SZ_W-1:0] count_nxt;
    logic [SZ_W-1:0] idx_nxt;

    always_comb begin
        count_nxt = count;
        if (inc_en) count_nxt = count_nxt + inc_amt;
        if (dec_en) count_nxt = count_nxt - dec_amt;
        idx_nxt = idx;
        if (step) idx_nxt = (idx == size - SZ_W'(1)) ? '0 : idx + SZ_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            idx   <= '0;
        end else if (clear) begin
            count <= '0;
            idx   <= '0;
        end else begin
            count <= count_nxt;
            idx   <= idx_nxt;
        end
    end

    AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= size); // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (size != '0) |-> (idx < size)); // R3
endmodule

// File: rtl/jring_coalesce.sv
module jring_coalesce #(
    parameter int CNT_THR_W = 8,
    parameter int TMR_THR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 done,
    input  logic                 coal_en,
    input  logic [CNT_THR_W-1:0] cnt_thr,
    input  logic [TMR_THR_W-1:0] tmr_thr,
    output logic                 fire
);
    localparam int PW = CNT_THR_W + 1;

    logic [CNT_THR_W-1:0] pend;
    logic [TMR_THR_W-1:0] tmr;
    logic [PW-1:0]        thr_eff;
    logic                 cnt_hit;
    logic                 tmr_hit;

    always_comb begin
        thr_eff = (cnt_thr == '0) ? PW'(1) : {1'b0, cnt_thr};
        cnt_hit = done && (({1'b0, pend} + PW'(1)) >= thr_eff);
        tmr_hit = (pend != '0) && (tmr_thr != '0) && (tmr >= tmr_thr);
        fire    = coal_en ? (cnt_hit || tmr_hit) : done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            tmr  <= '0;
        end else if (clear || !coal_en || fire) begin
            pend <= '0;
            tmr  <= '0;
        end else begin
            if (done) pend <= pend + CNT_THR_W'(1);
            tmr <= (pend != '0) ? tmr + TMR_THR_W'(1) : '0;
        end
    end

    AST_COAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pend == '0)); // R9
endmodule

// File: rtl/jring_halt_fsm.sv
module jring_halt_fsm
    import jring_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  logic     idle,
    input  logic     release_ack,
    output halt_st_e state,
    output logic     clear_now,
    output logic     halted
);
    halt_st_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            HS_RUN:   if (req)         nxt = HS_DRAIN;
            HS_DRAIN: if (idle)        nxt = HS_DONE;
            HS_DONE:  if (release_ack) nxt = HS_RUN;
            default:                   nxt = HS_RUN;
        endcase
    end

    always_comb begin
        clear_now = (state == HS_DRAIN) && idle;
        halted    = (state != HS_RUN);
    end

    AST_DONE_FROM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_DONE && $past(state) != HS_DONE) |-> ($past(state) == HS_DRAIN)); // R13
    AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_DRAIN && !idle) |=> (state == HS_DRAIN)); // R13
endmodule

// File: rtl/jring_ctl.sv
module jring_ctl
    import jring_pkg::*;
#(
    parameter int SZ_W      = 10,
    parameter int CNT_THR_W = 8,
    parameter int TMR_THR_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_fetch,
    input  logic        eng_done,
    output logic        eng_can_fetch,
    output logic        irq
);
    localparam int DW        = 32;
    localparam int CNT_LSB   = 8;
    localparam int TMR_LSB   = 16;
    localparam int HALT_LSB  = 2;
    localparam int ETYPE_LSB = 8;
    localparam int ACK_BIT   = 3;

    logic [SZ_W-1:0]      in_size, out_size;
    logic [SZ_W-1:0]      in_cnt, out_cnt, rd_idx, wr_idx, outst;
    logic [SZ_W-1:0]      in_avail;
    logic [SZ_W:0]        out_used;
    logic                 int_flag, err_flag;
    logic [3:0]           err_type;
    logic                 cfg_mask, cfg_coal, cfg_soe;
    logic [CNT_THR_W-1:0] cfg_cnt;
    logic [TMR_THR_W-1:0] cfg_tmr;
    halt_st_e             hs;
    logic                 halt_clear, halted, coal_fire;

    logic wr_in_size, wr_out_size, wr_status, wr_cfg, halt_req, ack;
    logic add_req, add_ok, add_ovf, rem_req, rem_ok, rem_ovf, halt_rej;
    logic fetch_ok, done_ok;

    always_comb begin
        in_avail    = in_size - in_cnt;
        out_used    = {1'b0, out_cnt} + {1'b0, outst};
        wr_in_size  = reg_wr && reg_addr == A_IN_SIZE && in_cnt == '0;
        wr_out_size = reg_wr && reg_addr == A_OUT_SIZE && out_cnt == '0 && outst == '0;
        wr_status   = reg_wr && reg_addr == A_STATUS;
        wr_cfg      = reg_wr && reg_addr == A_CONFIG;
        halt_req    = reg_wr && reg_addr == A_CMD && reg_wdata[0];
        ack         = wr_status && reg_wdata[ACK_BIT];
        add_req     = reg_wr && reg_addr == A_IN_ADD;
        rem_req     = reg_wr && reg_addr == A_OUT_REMOVE;
        add_ok      = add_req && !halted && reg_wdata <= DW'(in_avail);
        add_ovf     = add_req && !halted && reg_wdata >  DW'(in_avail);
        rem_ok      = rem_req && !halted && reg_wdata <= DW'(out_cnt);
        rem_ovf     = rem_req && !halted && reg_wdata >  DW'(out_cnt);
        halt_rej    = (add_req || rem_req) && halted;
        eng_can_fetch = (hs == HS_RUN) && (in_cnt != '0)
                        && (out_used < {1'b0, out_size})
                        && !(cfg_soe && err_flag);
        fetch_ok    = eng_fetch && eng_can_fetch;
        done_ok     = eng_done && (outst != '0);
        irq         = !cfg_mask && (int_flag || err_flag);
    end

    // sizes and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_size  <= '0;
            out_size <= '0;
            cfg_mask <= 1'b0;
            cfg_coal <= 1'b0;
            cfg_soe  <= 1'b0;
            cfg_cnt  <= '0;
            cfg_tmr  <= '0;
        end else begin
            if (wr_in_size)  in_size  <= reg_wdata[SZ_W-1:0];
            if (wr_out_size) out_size <= reg_wdata[SZ_W-1:0];
            if (wr_cfg) begin
                cfg_mask <= reg_wdata[0];
                cfg_coal <= reg_wdata[1];
                cfg_soe  <= reg_wdata[2];
                cfg_cnt  <= reg_wdata[CNT_LSB +: CNT_THR_W];
                cfg_tmr  <= reg_wdata[TMR_LSB +: TMR_THR_W];
            end
        end
    end

    // outstanding engine jobs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          outst <= '0;
        else if (halt_clear) outst <= '0;
        else                 outst <= outst + SZ_W'(fetch_ok) - SZ_W'(done_ok);
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_flag <= 1'b0;
            err_flag <= 1'b0;
            err_type <= ERR_NONE;
        end else begin
            if (coal_fire)                      int_flag <= 1'b1;
            else if (wr_status && reg_wdata[0]) int_flag <= 1'b0;
            if (add_ovf) begin
                err_flag <= 1'b1;
                err_type <= ERR_ADD_OVF;
            end else if (rem_ovf) begin
                err_flag <= 1'b1;
                err_type <= ERR_REM_OVF;
            end else if (halt_rej) begin
                err_flag <= 1'b1;
                err_type <= ERR_RESET;
            end else if (wr_status && reg_wdata[1]) begin
                err_flag <= 1'b0;
                err_type <= ERR_NONE;
            end
        end
    end

    jring_ring #(.SZ_W(SZ_W)) u_in_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (halt_clear || wr_in_size),
        .size    (in_size),
        .inc_en  (add_ok),
        .inc_amt (reg_wdata[SZ_W-1:0]),
        .dec_en  (fetch_ok),
        .dec_amt (SZ_W'(1)),
        .step    (fetch_ok),
        .count   (in_cnt),
        .idx     (rd_idx)
    );

    jring_ring #(.SZ_W(SZ_W)) u_out_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (halt_clear || wr_out_size),
        .size    (out_size),
        .inc_en  (done_ok),
        .inc_amt (SZ_W'(1)),
        .dec_en  (rem_ok),
        .dec_amt (reg_wdata[SZ_W-1:0]),
        .step    (done_ok),
        .count   (out_cnt),
        .idx     (wr_idx)
    );

    jring_coalesce #(.CNT_THR_W(CNT_THR_W), .TMR_THR_W(TMR_THR_W)) u_coal (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (halt_clear),
        .done    (done_ok),
        .coal_en (cfg_coal),
        .cnt_thr (cfg_cnt),
        .tmr_thr (cfg_tmr),
        .fire    (coal_fire)
    );

    jring_halt_fsm u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (halt_req),
        .idle        (outst == '0),
        .release_ack (ack),
        .state       (hs),
        .clear_now   (halt_clear),
        .halted      (halted)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_IN_SIZE:  reg_rdata[SZ_W-1:0] = in_size;
            A_IN_AVAIL: reg_rdata[SZ_W-1:0] = in_avail;
            A_OUT_SIZE: reg_rdata[SZ_W-1:0] = out_size;
            A_OUT_FULL: reg_rdata[SZ_W-1:0] = out_cnt;
            A_RD_IDX:   reg_rdata[SZ_W-1:0] = rd_idx;
            A_WR_IDX:   reg_rdata[SZ_W-1:0] = wr_idx;
            A_STATUS: begin
                reg_rdata[0]                 = int_flag;
                reg_rdata[1]                 = err_flag;
                reg_rdata[HALT_LSB +: 2]     = hs;
                reg_rdata[ETYPE_LSB +: 4]    = err_type;
            end
            A_CONFIG: begin
                reg_rdata[0]                    = cfg_mask;
                reg_rdata[1]                    = cfg_coal;
                reg_rdata[2]                    = cfg_soe;
                reg_rdata[CNT_LSB +: CNT_THR_W] = cfg_cnt;
                reg_rdata[TMR_LSB +: TMR_THR_W] = cfg_tmr;
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_ADD_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        add_ovf |=> (in_cnt == $past(in_cnt) - SZ_W'($past(fetch_ok)))); // R5
    AST_REM_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rem_ovf |=> (out_cnt == $past(out_cnt) + SZ_W'($past(done_ok)))); // R6
    AST_OUT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        out_used <= {1'b0, out_size}); // R3
    AST_ERR_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_type != ERR_NONE)); // R7
    AST_HALT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (hs == HS_DONE) |-> (in_cnt == '0 && out_cnt == '0 && outst == '0)); // R13
endmodule

// File: tb/tb_jring_ctl.sv
module tb_jring_ctl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        eng_fetch = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_can_fetch;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // model of the rings for the random phase
    int m_isz, m_osz, m_pend, m_rd, m_full, m_wr, m_outst;

    always #(CLK_P/2) clk = ~clk;

    jring_ctl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_fetch(eng_fetch),
        .eng_done(eng_done), .eng_can_fetch(eng_can_fetch), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic fetch1();
        @(negedge clk); eng_fetch = 1'b1;
        @(negedge clk); eng_fetch = 1'b0;
    endtask

    task automatic done1();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    function automatic int exp_avail(input int sz, input int pend);
        return sz - pend;
    endfunction

    function automatic int wrap_inc(input int i, input int sz);
        return (i + 1 == sz) ? 0 : i + 1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd1, v);  check("R1 avail", v, 0);
        rd(4'd5, v);  check("R1 full", v, 0);
        rd(4'd6, v);  check("R1 status", v, 0);
        rd(4'd7, v);  check("R1 config", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 can_fetch", {31'd0, eng_can_fetch}, 0);

        // R2 sizes masked to 10 bits
        wr(4'd0, 32'h0000_0C08);
        wr(4'd3, 32'd4);
        rd(4'd0, v);  check("R2 size mask", v, 8);
        rd(4'd1, v);  check("R2 avail", v, 8);

        // R3 add jobs
        wr(4'd2, 32'd3);
        rd(4'd1, v);  check("R3 avail after add", v, 5);
        check("R3 can_fetch", {31'd0, eng_can_fetch}, 1);
        wr(4'd0, 32'd16);
        rd(4'd0, v);  check("R2 size write ignored when busy", v, 8);

        // R5 add overflow
        wr(4'd2, 32'd6);
        rd(4'd1, v);  check("R5 avail unchanged", v, 5);
        rd(4'd6, v);  check("R5 status", v, 32'h902);
        check("R11 irq on error", {31'd0, irq}, 1);
        wr(4'd7, 32'h1);
        check("R11 irq masked", {31'd0, irq}, 0);
        wr(4'd6, 32'h2);
        rd(4'd6, v);  check("R7 w1c error", v, 0);
        wr(4'd7, 32'h0);

        // R3 fetch three
        fetch1(); fetch1(); fetch1();
        rd(4'd8, v);  check("R3 read index", v, 3);
        rd(4'd1, v);  check("R3 avail after fetch", v, 8);
        check("R3 no pending", {31'd0, eng_can_fetch}, 0);

        // R4 / R8 completion
        done1();
        rd(4'd5, v);  check("R4 full", v, 1);
        rd(4'd9, v);  check("R4 write index", v, 1);
        rd(4'd6, v);  check("R8 completion flag", v, 1);
        wr(4'd6, 32'h1);

        // R6 remove overflow
        wr(4'd4, 32'd2);
        rd(4'd6, v);  check("R6 status", v, 32'h802);
        rd(4'd5, v);  check("R6 full unchanged", v, 1);
        wr(4'd6, 32'h2);
        wr(4'd4, 32'd1);
        rd(4'd5, v);  check("R4 removed", v, 0);

        // R9 count coalescing, threshold 2
        wr(4'd7, 32'h0000_0202);
        done1();
        rd(4'd6, v);  check("R9 below threshold", v, 0);
        done1();
        rd(4'd6, v);  check("R9 at threshold", v, 1);
        wr(4'd6, 32'h1);
        wr(4'd4, 32'd2);

        // R10 timer coalescing, count 5, timer 6
        wr(4'd2, 32'd1);
        fetch1();
        wr(4'd7, (32'd6 << 16) | (32'd5 << 8) | 32'h2);
        done1();
        repeat (4) @(negedge clk);
        rd(4'd6, v);  check("R10 timer not yet", v, 0);
        repeat (4) @(negedge clk);
        rd(4'd6, v);  check("R10 timer fired", v, 1);
        wr(4'd6, 32'h1);
        wr(4'd7, 32'h0);
        wr(4'd4, 32'd1);

        // R12 stop on error
        wr(4'd7, 32'h4);
        wr(4'd2, 32'd1);
        wr(4'd2, 32'd100);
        check("R12 fetch blocked", {31'd0, eng_can_fetch}, 0);
        wr(4'd6, 32'h2);
        check("R12 fetch resumes", {31'd0, eng_can_fetch}, 1);
        wr(4'd7, 32'h0);

        // R13 ring reset handshake
        fetch1();
        wr(4'd2, 32'd2);
        wr(4'd10, 32'h1);
        rd(4'd6, v);  check("R13 draining", v & 32'hC, 32'h4);
        check("R13 fetch blocked", {31'd0, eng_can_fetch}, 0);
        wr(4'd2, 32'd1);
        rd(4'd6, v);  check("R13 reject type", v & 32'hF0E, 32'h706);
        done1();
        @(negedge clk);
        rd(4'd6, v);  check("R13 complete", v & 32'hC, 32'h8);
        rd(4'd1, v);  check("R13 avail cleared", v, 8);
        rd(4'd8, v);  check("R13 rd idx cleared", v, 0);
        rd(4'd9, v);  check("R13 wr idx cleared", v, 0);
        rd(4'd5, v);  check("R13 full cleared", v, 0);
        wr(4'd6, 32'hB);
        rd(4'd6, v);  check("R13 back to run", v, 0);

        // random phase (R3 R4 R5 R6)
        m_isz = 13; m_osz = 6;
        m_pend = 0; m_rd = 0; m_full = 0; m_wr = 0; m_outst = 0;
        wr(4'd0, 32'd13);
        wr(4'd3, 32'd6);
        for (int it = 0; it < 300; it++) begin
            int op;
            int n;
            op = int'($urandom % 4);
            case (op)
                0: begin
                    n = int'($urandom % 8);
                    wr(4'd2, n);
                    if (n <= m_isz - m_pend) m_pend += n;
                    else begin
                        rd(4'd6, v); check("R5 random add overflow", v & 32'hF02, 32'h902);
                    end
                    wr(4'd6, 32'h3);
                end
                1: begin
                    logic can;
                    can = (m_pend > 0) && (m_full + m_outst < m_osz);
                    check("R3 random can_fetch", {31'd0, eng_can_fetch}, {31'd0, can});
                    if (can) begin
                        fetch1();
                        m_pend--; m_rd = wrap_inc(m_rd, m_isz); m_outst++;
                    end
                end
                2: begin
                    if (m_outst > 0) begin
                        done1();
                        m_full++; m_wr = wrap_inc(m_wr, m_osz); m_outst--;
                        wr(4'd6, 32'h1);
                    end
                end
                default: begin
                    n = int'($urandom % 4);
                    wr(4'd4, n);
                    if (n <= m_full) m_full -= n;
                    else begin
                        rd(4'd6, v); check("R6 random remove overflow", v & 32'hF02, 32'h802);
                    end
                    wr(4'd6, 32'h3);
                end
            endcase
            rd(4'd1, v); check("R3 random avail", v, exp_avail(m_isz, m_pend));
            rd(4'd5, v); check("R4 random full", v, m_full);
            rd(4'd8, v); check("R3 random rd idx", v, m_rd);
            rd(4'd9, v); check("R4 random wr idx", v, m_wr);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule